// File: doc/BRIEF.md
# Pattern-Table Bank Mapper

This block turns the 13-bit pattern-table address issued by the video side into a wide address into a shared ROM. The 8 KB pattern space is cut into eight 1 KB slots, and each slot is given a page number. That page number is assembled from a selectable inner bank value and an outer block. The outer block sits above the inner bank, and a mode field sets how many bits of the page belong to each part. The block also keeps the nametable mirroring choice.

The processor configures the block by writing bytes on a shared write bus. There are three ways in:
- a bank register file in the 0x2010–0x201F window;
- a small set of system registers in the 0x4100–0x410F window;
- a command/data pair of registers in the upper half of the address space.

With the command/data pair, a command index picks one bank register and the next data write loads it. All state is held in flops. Translation is purely combinational from the stored state and the current pattern address.

Top module: `chr_bank_mapper`

## Requirements
- R1: While reset is asserted, and after it, every stored value is zero. So slot 1 (addresses 0x0400–0x07FF) maps to page 1, every other slot maps to page 0, and `mirror_o` reads 1.
- R2: A write to 0x2010+n stores the byte in bank register n. The new value shows on `chr_addr` after the next rising clock edge. Only registers 2–8 and 0xA affect the outputs.
- R3: A write to any address whose bits AND 0xE001 equal 0x8000, or a write to 0x4105, loads the command. Data bit 7 is the swap flag and data bits 2:0 are the index.
- R4: A write decoding to 0x8001 loads bank register 6, 7, 2, 3, 4 or 5 for command index 0, 1, 2, 3, 4 or 5 respectively. Indices 6 and 7 leave all outputs unchanged.
- R5: The slot is pattern address bits 12:10 after any swap. Slots 0 and 1 use register 6 with bit 0 forced to 0 and to 1. Slots 2 and 3 do the same with register 7. Slots 4 to 7 use registers 2, 3, 4 and 5.
- R6: When the swap flag is 1, pattern address bit 12 is inverted before the slot is chosen.
- R7: Register 0xA bits 2:0 give a shift through the table {0,1,2,0,3,4,5,0}. The inner mask is 0xFF shifted right by that amount.
- R8: The page is the sum of (0x4100 bits 3:0)·2048, (register 8 bits 6:4)·256, (register 0xA AND NOT mask) and (slot bank AND mask).
- R9: `mirror_o` is the inverse of data bit 0 of the last write decoding to 0xA000 (address AND 0xE001) or to 0x4106.
- R10: Writes elsewhere (for example 0xA001, 0xC000, 0xE001, 0x2020, 0x200F, 0x4110) and cycles with `wr_en` low change no output.
- R11: `chr_addr` is {page[14:0], pattern address bits 9:0} and follows `ppu_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Processor write strobe |
| wr_addr | input | 16 | Processor write address |
| wr_data | input | 8 | Processor write data |
| ppu_addr | input | 13 | Pattern-table address |
| chr_addr | output | 25 | Extended ROM address |
| mirror_o | output | 1 | Nametable mirroring select |

## Verification
A write is captured on the rising edge at which `wr_en` is high, so its effect on `chr_addr` and `mirror_o` is due one edge later. Translation of `ppu_addr` adds no delay at all. The bench drives each write at a falling edge and drops the strobe at the next falling edge. It then changes `ppu_addr` and samples one nanosecond later, away from any rising edge. Every check therefore sees exactly one completed register update and a settled combinational path.

// File: rtl/chrmap_pkg.sv
package chrmap_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned OUTER_W = 4;
  localparam int unsigned MID_W   = 3;
  localparam int unsigned SLOT_W  = 3;
  localparam int unsigned OFS_W   = 10;
  localparam int unsigned NBANK   = 6;
  localparam int unsigned PPU_AW  = SLOT_W + OFS_W;
  localparam int unsigned PAGE_W  = OUTER_W + MID_W + REG_W;
  localparam int unsigned CHR_AW  = PAGE_W + OFS_W;

  function automatic logic [2:0] mask_shift(input logic [2:0] sel);
    case (sel)
      3'd1: return 3'd1;
      3'd2: return 3'd2;
      3'd4: return 3'd3;
      3'd5: return 3'd4;
      3'd6: return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] inner_mask(input logic [2:0] sel);
    return {REG_W{1'b1}} >> mask_shift(sel);
  endfunction

  function automatic logic [REG_W-1:0] bank_pick(input logic [NBANK-1:0][REG_W-1:0] r,
                                                 input logic [SLOT_W-1:0] slot);
    case (slot)
      3'd0: return {r[4][REG_W-1:1], 1'b0};
      3'd1: return {r[4][REG_W-1:1], 1'b1};
      3'd2: return {r[5][REG_W-1:1], 1'b0};
      3'd3: return {r[5][REG_W-1:1], 1'b1};
      default: return r[slot - 3'd4];
    endcase
  endfunction

  function automatic logic [PAGE_W-1:0] page_of(input logic [OUTER_W-1:0] outer,
                                               input logic [MID_W-1:0] mid,
                                               input logic [REG_W-1:0] mode,
                                               input logic [REG_W-1:0] bank);
    logic [REG_W-1:0] m;
    m = inner_mask(mode[2:0]);
    return {outer, {(MID_W+REG_W){1'b0}}}
         + {{OUTER_W{1'b0}}, mid, {REG_W{1'b0}}}
         + {{(OUTER_W+MID_W){1'b0}}, mode & ~m}
         + {{(OUTER_W+MID_W){1'b0}}, bank & m};
  endfunction
endpackage

// File: rtl/chrmap_regs.sv
module chrmap_regs
  import chrmap_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [15:0]                     wr_addr,
  input  logic [REG_W-1:0]                wr_data,
  output logic [NBANK-1:0][REG_W-1:0]     bank_regs,
  output logic [REG_W-1:0]                mode_q,
  output logic [MID_W-1:0]                mid_q,
  output logic [OUTER_W-1:0]              outer_q,
  output logic                            swap_q,
  output logic                            mirror_q
);
  logic [2:0] idx_q;
  logic [REG_W-1:0] bank_q [NBANK];

  logic ppu_sel, cpu_sel, cmd_wr, dat_wr, mir_wr;
  assign ppu_sel = wr_en && (wr_addr[15:4] == 12'h201);
  assign cpu_sel = wr_en && (wr_addr[15:4] == 12'h410);
  assign cmd_wr  = (wr_en && ((wr_addr & 16'hE001) == 16'h8000)) || (cpu_sel && wr_addr[3:0] == 4'h5);
  assign dat_wr  = wr_en && ((wr_addr & 16'hE001) == 16'h8001);
  assign mir_wr  = (wr_en && ((wr_addr & 16'hE001) == 16'hA000)) || (cpu_sel && wr_addr[3:0] == 4'h6);

  for (genvar k = 0; k < NBANK; k++) begin : g_bank
    localparam logic [3:0] FILE_IDX = 4'(k + 2);
    localparam logic [2:0] CMD_IDX  = (k < 4) ? 3'(k + 2) : 3'(k - 4);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank_q[k] <= '0;
      else if ((ppu_sel && wr_addr[3:0] == FILE_IDX) || (dat_wr && idx_q == CMD_IDX))
        bank_q[k] <= wr_data;
    end
    assign bank_regs[k] = bank_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      mid_q    <= '0;
      outer_q  <= '0;
      swap_q   <= 1'b0;
      idx_q    <= '0;
      mirror_q <= 1'b0;
    end else begin
      if (ppu_sel && wr_addr[3:0] == 4'hA) mode_q <= wr_data;
      if (ppu_sel && wr_addr[3:0] == 4'h8) mid_q <= wr_data[6:4];
      if (cpu_sel && wr_addr[3:0] == 4'h0) outer_q <= wr_data[OUTER_W-1:0];
      if (cmd_wr) begin
        swap_q <= wr_data[7];
        idx_q  <= wr_data[2:0];
      end
      if (mir_wr) mirror_q <= wr_data[0];
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (bank_regs == '0 && mode_q == '0 && mid_q == '0 && outer_q == '0 && !swap_q && !mirror_q)); // R1
  AST_FILE_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (ppu_sel && wr_addr[3:0] == 4'h3) |=> bank_regs[1] == $past(wr_data)); // R2
  AST_CMD_LOAD: assert property (@(posedge clk) disable iff (!rst_n) cmd_wr |=> (swap_q == $past(wr_data[7]) && idx_q == $past(wr_data[2:0]))); // R3
  AST_DATA_ROUTE: assert property (@(posedge clk) disable iff (!rst_n) (dat_wr && idx_q == 3'd0) |=> bank_regs[4] == $past(wr_data)); // R4
  AST_HIGH_IDX_INERT: assert property (@(posedge clk) disable iff (!rst_n) (dat_wr && idx_q[2:1] == 2'b11) |=> $stable(bank_regs)); // R4
endmodule

// File: rtl/chrmap_xlate.sv
module chrmap_xlate
  import chrmap_pkg::*;
(
  input  logic [PPU_AW-1:0]               ppu_addr,
  input  logic [NBANK-1:0][REG_W-1:0]     bank_regs,
  input  logic [REG_W-1:0]                mode_q,
  input  logic [MID_W-1:0]                mid_q,
  input  logic [OUTER_W-1:0]              outer_q,
  input  logic                            swap_q,
  output logic [PAGE_W-1:0]               page
);
  logic [SLOT_W-1:0] slot;
  logic [REG_W-1:0]  bank_raw;

  assign slot     = ppu_addr[PPU_AW-1:OFS_W] ^ {swap_q, {(SLOT_W-1){1'b0}}};
  assign bank_raw = bank_pick(bank_regs, slot);
  assign page     = page_of(outer_q, mid_q, mode_q, bank_raw);

  always_comb begin
    AST_PAIR_PARITY: assert (slot[2] || bank_raw[0] == slot[0]); // R5
    AST_OUTER_TOP: assert (page[PAGE_W-1 -: OUTER_W] == outer_q); // R8
  end
endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
  import chrmap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [15:0]          wr_addr,
  input  logic [7:0]           wr_data,
  input  logic [12:0]          ppu_addr,
  output logic [24:0]          chr_addr,
  output logic                 mirror_o
);
  logic [NBANK-1:0][REG_W-1:0] bank_regs;
  logic [REG_W-1:0]            mode_q;
  logic [MID_W-1:0]            mid_q;
  logic [OUTER_W-1:0]          outer_q;
  logic                        swap_q;
  logic                        mirror_q;
  logic [PAGE_W-1:0]           page;

  chrmap_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bank_regs(bank_regs), .mode_q(mode_q), .mid_q(mid_q), .outer_q(outer_q),
    .swap_q(swap_q), .mirror_q(mirror_q)
  );

  chrmap_xlate u_xlate (
    .ppu_addr(ppu_addr), .bank_regs(bank_regs), .mode_q(mode_q), .mid_q(mid_q),
    .outer_q(outer_q), .swap_q(swap_q), .page(page)
  );

  assign chr_addr = {page, ppu_addr[OFS_W-1:0]};
  assign mirror_o = ~mirror_q;

  AST_MIRROR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && (wr_addr & 16'hE001) == 16'hA000) |=> mirror_o == !$past(wr_data[0])); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(mirror_o)); // R10
endmodule

// File: tb/chr_bank_mapper_test.sv
`timescale 1ns/1ps
module chr_bank_mapper_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [12:0] ppu_addr = '0;
  logic [24:0] chr_addr;
  logic mirror_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  chr_bank_mapper uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ppu_addr(ppu_addr), .chr_addr(chr_addr), .mirror_o(mirror_o)
  );

  // independent shadow of the programmed state
  logic [7:0] sh_file [16];
  logic [3:0] sh_outer;
  logic       sh_swap;
  logic [2:0] sh_idx;
  logic       sh_mir;

  task automatic shadow_clear();
    for (int i = 0; i < 16; i++) sh_file[i] = 8'h00;
    sh_outer = 0; sh_swap = 0; sh_idx = 0; sh_mir = 0;
  endtask

  function automatic logic [14:0] ref_page(input logic [12:0] a);
    int sh, sel, r, v, m, pg;
    case (sh_file[10][2:0])
      3'd1: sh = 1; 3'd2: sh = 2; 3'd4: sh = 3; 3'd5: sh = 4; 3'd6: sh = 5;
      default: sh = 0;
    endcase
    m = 255 / (1 << sh);
    sel = int'(a[12:10]);
    if (sh_swap) sel = sel ^ 4;
    if (sel < 2) begin r = 6; end else if (sel < 4) begin r = 7; end else r = sel - 2;
    v = int'(sh_file[r]);
    if (sel < 4) v = (v & 254) | (sel & 1);
    pg = int'(sh_outer) * 2048 + int'(sh_file[8][6:4]) * 256
       + (int'(sh_file[10]) & (255 - m)) + (v & m);
    return 15'(pg);
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a[15:4] == 12'h201) sh_file[a[3:0]] = d;
    if (a[15:4] == 12'h410) begin
      if (a[3:0] == 4'h0) sh_outer = d[3:0];
      if (a[3:0] == 4'h5) begin sh_swap = d[7]; sh_idx = d[2:0]; end
      if (a[3:0] == 4'h6) sh_mir = d[0];
    end
    if ((a & 16'hE001) == 16'h8000) begin sh_swap = d[7]; sh_idx = d[2:0]; end
    if ((a & 16'hE001) == 16'hA000) sh_mir = d[0];
    if ((a & 16'hE001) == 16'h8001) begin
      case (sh_idx)
        3'd0: sh_file[6] = d;
        3'd1: sh_file[7] = d;
        3'd2: sh_file[2] = d;
        3'd3: sh_file[3] = d;
        3'd4: sh_file[4] = d;
        3'd5: sh_file[5] = d;
        default: ;
      endcase
    end
  endtask

  task automatic check(input string tag, input logic [12:0] a,
                       input logic [14:0] exp_pg, input logic exp_mir);
    logic [24:0] exp_a;
    ppu_addr = a;
    #1;
    exp_a = {exp_pg, a[9:0]};
    n_chk++;
    if (chr_addr !== exp_a) begin
      n_bad++;
      $display("FAIL %s: ppu %h chr_addr got %h expected %h", tag, a, chr_addr, exp_a);
    end
    n_chk++;
    if (mirror_o !== exp_mir) begin
      n_bad++;
      $display("FAIL %s: mirror_o got %b expected %b", tag, mirror_o, exp_mir);
    end
  endtask

  task automatic check_model(input string tag);
    for (int s = 0; s < 8; s++) begin
      logic [12:0] a;
      a = 13'(s * 1024 + 37 * s + 5);
      check(tag, a, ref_page(a), ~sh_mir);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  data;
    logic [12:0] probe;
    logic [14:0] page;
    logic        mir;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{16'h2016, 8'h35, 13'h045A, 15'h0035, 1'b1},  // R2 R5 slot 1 forces bit0
    '{16'h2017, 8'h48, 13'h0801, 15'h0048, 1'b1},  // R5 slot 2
    '{16'h2012, 8'h9A, 13'h13FF, 15'h009A, 1'b1},  // R5 slot 4
    '{16'h201A, 8'h05, 13'h1000, 15'h000A, 1'b1},  // R7 sel 5 -> mask 0x0F
    '{16'h201A, 8'hE3, 13'h0400, 15'h0035, 1'b1},  // R7 sel 3 -> full mask
    '{16'h201A, 8'hA6, 13'h0C10, 15'h00A1, 1'b1},  // R7 sel 6 -> mask 0x07
    '{16'h2018, 8'h5F, 13'h0C10, 15'h05A1, 1'b1},  // R8 middle bits
    '{16'h4100, 8'h0C, 13'h0C10, 15'h65A1, 1'b1},  // R8 outer bits
    '{16'h8000, 8'h80, 13'h0C10, 15'h65A0, 1'b1},  // R6 swap
    '{16'hA000, 8'h01, 13'h0C10, 15'h65A0, 1'b0}   // R9 mirror
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    shadow_clear();
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check("R1", 13'h0400, 15'h0001, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 13'h0400, 15'h0001, 1'b1);
    check("R1", 13'h1C00, 15'h0000, 1'b1);

    foreach (VEC[i]) begin
      wr(VEC[i].addr, VEC[i].data);
      check($sformatf("R2/R5-R9 vec%0d", i), VEC[i].probe, VEC[i].page, VEC[i].mir);
    end

    // R11: combinational sweep with swap on, then off via 0x4105 (R3)
    check_model("R11");
    wr(16'h4105, 8'h00);
    check_model("R3 R6");

    // R4: every command index, including the inert ones
    for (int k = 0; k < 8; k++) begin
      wr(16'h8000, 8'(k));
      wr(16'h8001, 8'(8'hC1 + k * 7));
      check_model($sformatf("R4 idx%0d", k));
    end

    // R3: command write keeps only bit 7 and bits 2:0
    wr(16'h9FFE, 8'h85);
    wr(16'hBFFF, 8'h3C);
    check("R3", 13'h0C00, ref_page(13'h0C00), ~sh_mir);
    check_model("R3");

    // R10: writes with no effect
    wr(16'hA001, 8'h00);
    wr(16'hC000, 8'hFF);
    wr(16'hE001, 8'hFF);
    wr(16'h2020, 8'h77);
    wr(16'h200F, 8'h77);
    wr(16'h4110, 8'h0F);
    wr(16'h2019, 8'hFF);
    check_model("R10");
    @(negedge clk);
    wr_addr = 16'h2012; wr_data = 8'h00;
    repeat (2) @(negedge clk);
    check_model("R10 idle");

    // R9: mirror through 0x4106 and 0xBFFE
    wr(16'h4106, 8'h00);
    check("R9", 13'h0000, ref_page(13'h0000), 1'b1);
    wr(16'hBFFE, 8'hFF);
    check("R9", 13'h0000, ref_page(13'h0000), 1'b0);

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    shadow_clear();
    check("R1", 13'h0400, 15'h0001, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check_model("R1");

    done = 1'b1;
    report();
  end
endmodule